// File: doc/BRIEF.md
# DRAM Page-Mode Access Sequencer

This block drives the row strobe, column strobe, write strobe and multiplexed address pins of one DRAM channel on behalf of a bus master. A transfer is requested with `req` together with a start word address, a write flag, a burst flag and a burst word count. A single-word transfer always runs a complete row/column cycle and closes the row. A burst opens the row once and then steps through columns while the row strobe stays low. Each new column is issued by toggling only the column strobe.

While a burst is in page mode, the sequencer checks every next word before issuing it. A page miss occurs when the next word lies in a different row, or when the open page has already carried the configured number of words. On a miss the row strobe rises and is held high for a fixed precharge time. The next word then gets one full normal cycle with a fresh row address, and page mode resumes after it.

A configuration bit selects the column cycle. Fast page mode spends three clocks per page word and acknowledges while the column strobe is low. Extended-data-out mode spends two clocks per page word and acknowledges in the following clock, with the strobe high and the next column already on the address pins. The address is split as row = upper `ROW_W` bits and column = lower `COL_W` bits of the word address.

Top module: `dram_page_seq`

## Requirements
- R1: During and after reset `ras_n`, `cas_n` and `we_n` are 1, `ack` is 0, and the sequencer is idle.
- R2: A request with `burst`=0 transfers exactly one word with one row open and one `ack`, whatever `blen` holds, and then returns `ras_n` to 1.
- R3: When `ras_n` falls, `ma` carries the row. One clock later `ma` carries the column with `cas_n` still 1, and `cas_n` falls in the clock after that.
- R4: With `cfg_edo`=0, consecutive column strobes within one open row fall exactly 3 clocks apart, and each `ack` is given in a clock where `cas_n` is 0.
- R5: With `cfg_edo`=1, consecutive column strobes within one open row fall exactly 2 clocks apart. Each `ack` is given in the clock right after a `cas_n`=0 clock, with `cas_n` at 1.
- R6: If the next burst word has column 0 (it lies in the next row), the row is closed and reopened with the new row for that word. The following words continue in page mode.
- R7: If the open page has already carried `cfg_page_words` words, the next burst word forces a row close and reopen, even when the row is unchanged.
- R8: After each rise of `ras_n`, it stays at 1 for at least `PRECH` clocks (default 2) before it may fall again.
- R9: A burst transfers `blen`+1 words with consecutive word addresses, wrapping at the top of the address space. There is one single-clock `ack` pulse per word, and the column driven at each `cas_n` fall is that of the current word.
- R10: `we_n` is 0 through the whole row-open period of a write transfer and is 1 for reads and whenever `ras_n` is 1.
- R11: When the last word of a transfer completes, `ras_n`, `cas_n` and `we_n` return to 1. A new request is accepted only while idle.
- R12: `cas_n` is never 0 while `ras_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transfer request, sampled while idle |
| burst | input | 1 | 1 = burst of `blen`+1 words, 0 = single word |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ROW_W+COL_W | Start word address (row in upper bits) |
| blen | input | BLEN_W | Burst word count minus one |
| cfg_edo | input | 1 | 0 = fast page cycle, 1 = extended-data-out cycle |
| cfg_page_words | input | COL_W+1 | Maximum words per open page (at least 1) |
| ack | output | 1 | One-clock pulse per transferred word |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| ma | output | max(ROW_W,COL_W) | Multiplexed row/column address |

## Verification
A row change and a page-word-limit overflow can become due for the same burst word. This happens when the page limit is reached exactly at the last column of a row. Both must then produce a single close and reopen, not two. The bench provokes this with bursts that start a few columns below the row end while `cfg_page_words` is set to land on that boundary. Random small limits and random start columns add more cases. A bench function counts the expected row openings, and the number of `ras_n` falls must match that count. The row captured at each fall is compared with the expected row, and the precharge gap before each reopen is measured.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RAS,
    S_CADR,
    S_CASL,
    S_CASH,
    S_PRE
  } dps_state_e;
endpackage

// File: rtl/dps_addr_unit.sv
module dps_addr_unit #(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 8,
  parameter int BLEN_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [ROW_W+COL_W-1:0]  ld_addr,
  input  logic [BLEN_W-1:0]       ld_words,
  input  logic                    open_pg,
  input  logic                    step,
  input  logic [COL_W:0]          cfg_page_words,
  output logic [ROW_W+COL_W-1:0]  cur,
  output logic [ROW_W+COL_W-1:0]  nxt,
  output logic                    last,
  output logic                    miss
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int PG_W   = COL_W + 1;

  logic [ADDR_W-1:0] cur_q;
  logic [BLEN_W-1:0] rem_q;
  logic [PG_W-1:0]   pg_q;
  logic [PG_W:0]     pg_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      rem_q <= '0;
      pg_q  <= '0;
    end else begin
      if (load) begin
        cur_q <= ld_addr;
        rem_q <= ld_words;
      end else if (step && (rem_q != '0)) begin
        cur_q <= cur_q + 1'b1;
        rem_q <= rem_q - 1'b1;
      end
      if (open_pg)
        pg_q <= '0;
      else if (step)
        pg_q <= pg_q + 1'b1;
    end
  end

  assign pg_inc = {1'b0, pg_q} + 1'b1;
  assign cur    = cur_q;
  assign nxt    = cur_q + 1'b1;
  assign last   = (rem_q == '0);
  // next word leaves the row when the current column is the row's last one
  assign miss   = (&cur_q[COL_W-1:0]) || (pg_inc >= {1'b0, cfg_page_words});

  // words in one open page never exceed the configured limit
  assert_pg_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (step && cfg_page_words != '0) |-> (pg_q < cfg_page_words));
endmodule

// File: rtl/dps_prech_timer.sv
module dps_prech_timer #(
  parameter int PRECH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  localparam int CW = (PRECH < 2) ? 1 : $clog2(PRECH + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= CW'(PRECH - 1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq #(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 8,
  parameter int BLEN_W = 6,
  parameter int PRECH  = 2,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              burst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BLEN_W-1:0] blen,
  input  logic              cfg_edo,
  input  logic [COL_W:0]    cfg_page_words,
  output logic              ack,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [MA_W-1:0]   ma
);
  import dps_pkg::*;

  dps_state_e state_q, state_d;
  logic wr_q, edo_q, last_q, miss_q;
  logic load, step, open_pg, prech_done, prech_load;
  logic [ADDR_W-1:0] cur, nxt;
  logic last, miss;
  logic ack_d, ras_n_d, cas_n_d, we_n_d, wr_eff;
  logic [MA_W-1:0] ma_d;

  assign load       = (state_q == S_IDLE) && req;
  assign step       = (state_q == S_CASL);
  assign open_pg    = (state_d == S_RAS);
  assign prech_load = (state_d == S_PRE) && (state_q != S_PRE);

  dps_addr_unit #(.ROW_W(ROW_W), .COL_W(COL_W), .BLEN_W(BLEN_W)) u_addr (
    .clk(clk), .rst(rst), .load(load), .ld_addr(addr),
    .ld_words(burst ? blen : '0), .open_pg(open_pg), .step(step),
    .cfg_page_words(cfg_page_words), .cur(cur), .nxt(nxt),
    .last(last), .miss(miss)
  );

  dps_prech_timer #(.PRECH(PRECH)) u_prech (
    .clk(clk), .rst(rst), .load(prech_load), .done(prech_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (req) state_d = S_RAS;
      S_RAS:  state_d = S_CADR;
      S_CADR: state_d = S_CASL;
      S_CASL: state_d = S_CASH;
      S_CASH: begin
        if (last_q || miss_q) state_d = S_PRE;
        else if (edo_q)       state_d = S_CASL;
        else                  state_d = S_CADR;
      end
      S_PRE:  if (prech_done) state_d = last_q ? S_IDLE : S_RAS;
      default: state_d = S_IDLE;
    endcase
  end

  assign wr_eff = (state_q == S_IDLE) ? wr : wr_q;

  always_comb begin
    ras_n_d = !(state_d inside {S_RAS, S_CADR, S_CASL, S_CASH});
    cas_n_d = (state_d != S_CASL);
    we_n_d  = ras_n_d || !wr_eff;
    ack_d   = ((state_d == S_CASL) && !edo_q) || ((state_d == S_CASH) && edo_q);
    ma_d    = ma;
    unique case (state_d)
      S_RAS:  ma_d = MA_W'((state_q == S_IDLE) ? addr[ADDR_W-1:COL_W] : cur[ADDR_W-1:COL_W]);
      S_CADR: ma_d = MA_W'(cur[COL_W-1:0]);
      S_CASH: if (edo_q && !last && !miss) ma_d = MA_W'(nxt[COL_W-1:0]);
      default: ma_d = ma;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      wr_q    <= 1'b0;
      edo_q   <= 1'b0;
      last_q  <= 1'b1;
      miss_q  <= 1'b0;
      ack     <= 1'b0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      we_n    <= 1'b1;
      ma      <= '0;
    end else begin
      state_q <= state_d;
      if (load) begin
        wr_q  <= wr;
        edo_q <= cfg_edo;
      end
      if (step) begin
        last_q <= last;
        miss_q <= !last && miss;
      end
      ack   <= ack_d;
      ras_n <= ras_n_d;
      cas_n <= cas_n_d;
      we_n  <= we_n_d;
      ma    <= ma_d;
    end
  end

  // precharge window tracker for the R8 check
  localparam int HW = $clog2(PRECH + 2) + 1;
  logic [HW-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst)
      hi_run <= '1;
    else if (!ras_n)
      hi_run <= '0;
    else if (hi_run != '1)
      hi_run <= hi_run + 1'b1;
  end

  assert_prech_gap_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (hi_run >= HW'(PRECH)));
  assert_col_after_row_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |=> (!ras_n && cas_n));
  assert_cas_follows_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |=> ##1 !cas_n);
  assert_cas_inside_ras_R12: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);
  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  assert_fp_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (ack && !edo_q) |-> !cas_n);
  assert_edo_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (ack && edo_q) |-> (cas_n && $past(!cas_n)));
  assert_we_closed_R10: assert property (@(posedge clk) disable iff (rst)
    ras_n |-> we_n);
endmodule

// File: tb/dram_page_seq_tb.sv
module dram_page_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 10, COL_W = 8, BLEN_W = 6, PRECH = 2;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst = 1'b1;
  logic req = 1'b0, burst = 1'b0, wr = 1'b0, cfg_edo = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [BLEN_W-1:0] blen = '0;
  logic [COL_W:0] cfg_page_words = 9'd256;
  logic ack, ras_n, cas_n, we_n;
  logic [MA_W-1:0] ma;

  dram_page_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .BLEN_W(BLEN_W), .PRECH(PRECH)) u_dut (
    .clk(clk), .rst(rst), .req(req), .burst(burst), .wr(wr), .addr(addr),
    .blen(blen), .cfg_edo(cfg_edo), .cfg_page_words(cfg_page_words),
    .ack(ack), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ma(ma)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, widx = 0, acks = 0, opens = 0, hi_run = 99;
  int ras_fall_cyc = 0, last_cas_cyc = 0;
  bit ras_prev = 1, cas_prev = 1, first_cas = 0, done = 0;
  logic [ADDR_W-1:0] t_addr = '0;
  bit t_wr = 0, t_edo = 0;
  int t_n = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic logic [ADDR_W-1:0] addr_of(input int i);
    return t_addr + ADDR_W'(i);
  endfunction

  function automatic int exp_opens(input logic [ADDR_W-1:0] a0, input int n, input int pgw);
    int o = 1, pg = 0;
    logic [ADDR_W-1:0] a = a0;
    for (int i = 0; i < n; i++) begin
      if (i > 0 && (a[COL_W-1:0] == '0 || pg >= pgw)) begin
        o++;
        pg = 0;
      end
      pg++;
      a = a + 1'b1;
    end
    return o;
  endfunction

  // monitor samples away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      ras_prev = 1; cas_prev = 1; hi_run = 99;
    end else begin
      if (!ras_n && ras_prev) begin
        opens++;
        chk(hi_run >= PRECH, "R8 precharge gap", hi_run, PRECH);
        chk(int'(ma) == int'(addr_of(widx) >> COL_W), "R6 row at open", int'(ma), int'(addr_of(widx) >> COL_W));
        first_cas = 1;
        ras_fall_cyc = cyc;
      end
      if (!cas_n && cas_prev) begin
        chk(!ras_n, "R12 cas inside ras", ras_n, 0);
        chk(int'(ma) == int'(addr_of(widx) & ((1 << COL_W) - 1)), "R9 column", int'(ma), int'(addr_of(widx) & ((1 << COL_W) - 1)));
        chk(we_n == !t_wr, "R10 write strobe", we_n, !t_wr);
        if (first_cas)
          chk(cyc - ras_fall_cyc == 2, "R3 ras to cas", cyc - ras_fall_cyc, 2);
        else if (t_edo)
          chk(cyc - last_cas_cyc == 2, "R5 edo page spacing", cyc - last_cas_cyc, 2);
        else
          chk(cyc - last_cas_cyc == 3, "R4 fast page spacing", cyc - last_cas_cyc, 3);
        first_cas = 0;
        last_cas_cyc = cyc;
      end
      if (ack) begin
        if (t_edo) chk(cas_n == 1'b1 && !cas_prev, "R5 ack phase", cas_n, 1);
        else       chk(cas_n == 1'b0, "R4 ack phase", cas_n, 0);
        acks++;
        widx++;
      end
      if (ras_n) hi_run++; else hi_run = 0;
      ras_prev = ras_n;
      cas_prev = cas_n;
    end
  end

  task automatic run(input logic [ADDR_W-1:0] a, input bit b, input int bl,
                     input bit w, input bit e, input int pgw);
    @(negedge clk);
    t_addr = a; t_wr = w; t_edo = e;
    t_n = b ? bl + 1 : 1;
    widx = 0; acks = 0; opens = 0;
    addr = a; burst = b; blen = BLEN_W'(bl); wr = w;
    cfg_edo = e; cfg_page_words = (COL_W+1)'(pgw);
    req = 1'b1;
    while (acks < t_n) @(negedge clk);
    req = 1'b0;
    repeat (8) @(negedge clk);
    if (b) chk(acks == t_n, "R9 ack count", acks, t_n);
    else   chk(acks == 1, "R2 single word acks", acks, 1);
    if (b) chk(opens == exp_opens(a, t_n, pgw), "R6 R7 row openings", opens, exp_opens(a, t_n, pgw));
    else   chk(opens == 1, "R2 single word opens", opens, 1);
    chk(ras_n && cas_n && we_n, "R11 closed after transfer", {ras_n, cas_n, we_n}, 7);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && we_n && !ack, "R1 reset state", {ras_n, cas_n, we_n, ack}, 14);
    rst = 1'b0;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && !ack, "R1 idle after reset", {ras_n, cas_n, we_n, ack}, 14);

    run(18'h00123, 1'b0, 37, 1'b0, 1'b0, 256);   // R2 single word, blen ignored
    run(18'h04567, 1'b0, 12, 1'b1, 1'b1, 256);   // R2 single edo write
    run(18'h00010, 1'b1, 7, 1'b0, 1'b0, 256);    // R4 fast page burst
    run(18'h00010, 1'b1, 7, 1'b1, 1'b1, 256);    // R5 edo write burst
    run(18'h001FD, 1'b1, 5, 1'b0, 1'b0, 256);    // R6 row crossing
    run(18'h002FE, 1'b1, 4, 1'b1, 1'b1, 256);    // R6 row crossing, edo
    run(18'h00300, 1'b1, 9, 1'b0, 1'b0, 3);      // R7 page word limit
    run(18'h00340, 1'b1, 5, 1'b1, 1'b0, 1);      // R7 limit of one word
    run(18'h004FC, 1'b1, 7, 1'b0, 1'b1, 4);      // R6 R7 due on the same word
    run(18'h3FFFE, 1'b1, 3, 1'b1, 1'b0, 256);    // R9 wrap of address space

    for (int i = 0; i < 60; i++) begin
      logic [ADDR_W-1:0] ra;
      int pg;
      ra = ADDR_W'($urandom);
      if ($urandom % 3 == 0) ra[COL_W-1:0] = COL_W'(8'hF8 + ($urandom % 8));
      pg = ($urandom % 2) ? 256 : 1 + ($urandom % 6);
      run(ra, 1'($urandom), int'($urandom % 24), 1'($urandom), 1'($urandom), pg);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule